// File: doc/BRIEF.md
# Tick-Driven 8-Bit Timer with Compare Clear

An up-counting timer that advances only on cycles where an external prescaler raises a one-cycle tick enable. A 3-bit mode input selects how it counts. In free-running mode the count climbs through the whole range and rolls over. In compare-clear mode the compare register sets the top of the count, so the period is set by software. The timer raises two sticky event flags, one for rollover and one for compare match. An interrupt handler clears each flag through its own acknowledge input.

Software can load the count register and the compare register at any time through simple write strobes. The compare register takes a new value at once and keeps no shadow copy. If the new value is below the running count, the match is missed until the counter has wrapped. A single waveform pin can be set to flip its level on every compare match. This gives a square wave whose half-period is the compare value plus one tick.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset, count, compare, both flags and the waveform output are all 0.
- R2: With no count write, the count changes only on cycles with tick high. Mode values other than 0 and 2 hold the count even on ticks, and they raise no flag and no toggle.
- R3: Mode 0 (free-running) adds one per tick and wraps from 0xFF to 0x00. It never clears on compare.
- R4: The overflow flag is set by the same tick that carries the count from 0xFF to 0x00, in either mode, so it is seen together with the zero count.
- R5: A flag is cleared only by its acknowledge input. Hardware never clears it. When a set and an acknowledge fall in the same cycle, the flag ends up set.
- R6: In mode 2 (compare-clear), a tick taken while count equals compare loads 0 instead of count+1. Starting from 0, the count therefore repeats with a period of compare+1 ticks.
- R7: The compare flag is set by every tick taken while count equals compare, in mode 0 and in mode 2.
- R8: A compare write takes effect in the next cycle with no buffering. If the new value is below the count, the counter in mode 2 runs up to 0xFF, wraps (setting the overflow flag), and matches only when it reaches the new value.
- R9: A count write is accepted in any cycle and overrides that cycle's increment or clear. No compare match or overflow is flagged in a write cycle.
- R10: With the 2-bit output mode equal to 1, the waveform output flips on every compare match. Any other output mode holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from prescaler |
| mode | input | 3 | Counting mode: 0 free-running, 2 compare-clear |
| out_mode | input | 2 | Waveform mode: 1 toggle on match |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 8 | Count write value |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Compare write value |
| ovf_ack | input | 1 | Clears the overflow flag |
| cmp_ack | input | 1 | Clears the compare flag |
| count | output | 8 | Current count |
| compare | output | 8 | Current compare value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| wave_out | output | 1 | Toggling waveform output |

## Verification
A wrong count shows on the count port in the cycle after the faulty tick. In compare-clear mode it also moves every later match, so the compare flag and the waveform parity drift within one period. A missed or extra match shows up as a wave level that disagrees with the number of completed periods. An unflagged or wrongly cleared event shows on the flag ports in the cycle after the tick that caused it. The stale-compare case is the slowest to appear: it needs a full trip through 0xFF before the misplaced match becomes visible.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int MODE_W = 3;
  localparam int OMODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_FREE = 3'd0;
  localparam logic [MODE_W-1:0] MODE_CTC  = 3'd2;
  localparam logic [OMODE_W-1:0] OUT_TOGGLE = 2'd1;
  localparam int EV_OVF = 0;
  localparam int EV_CMP = 1;
  localparam int NUM_EV = 2;
endpackage

// File: rtl/tick_timer_count.sv
module tick_timer_count
  import tick_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [MODE_W-1:0] mode,
  input  logic              cnt_wr,
  input  logic [W-1:0]      cnt_wdata,
  input  logic [W-1:0]      compare,
  output logic [W-1:0]      count,
  output logic              match_ev,
  output logic              wrap_ev
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic          mode_ok;
  logic          active;
  logic          at_top;
  logic          at_max;
  logic [W-1:0]  count_nxt;

  always_comb begin
    mode_ok  = (mode == MODE_FREE) || (mode == MODE_CTC);
    active   = tick && !cnt_wr && mode_ok;
    at_top   = (count == compare);
    at_max   = (count == CNT_MAX);
    match_ev = active && at_top;
    wrap_ev  = active && at_max;
    if (cnt_wr) begin
      count_nxt = cnt_wdata;
    end else if (active) begin
      if ((mode == MODE_CTC) && at_top) count_nxt = '0;
      else                              count_nxt = count + 1'b1;
    end else begin
      count_nxt = count;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nxt;
  end
endmodule

// File: rtl/tick_timer_flag.sv
module tick_timer_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (ack) flag <= 1'b0;
  end
endmodule

// File: rtl/tick_timer_wave.sv
module tick_timer_wave
  import tick_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               match_ev,
  input  logic [OMODE_W-1:0] out_mode,
  output logic               wave
);
  always_ff @(posedge clk) begin
    if (rst)                                     wave <= 1'b0;
    else if (match_ev && (out_mode == OUT_TOGGLE)) wave <= ~wave;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic [1:0]   out_mode,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         ovf_ack,
  input  logic         cmp_ack,
  output logic [W-1:0] count,
  output logic [W-1:0] compare,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         wave_out
);
  logic                match_ev;
  logic                wrap_ev;
  logic [NUM_EV-1:0]   ev_set;
  logic [NUM_EV-1:0]   ev_ack;
  logic [NUM_EV-1:0]   ev_flag;

  always_ff @(posedge clk) begin
    if (rst)         compare <= '0;
    else if (cmp_wr) compare <= cmp_wdata;
  end

  tick_timer_count #(.W(W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .mode      (mode),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .compare   (compare),
    .count     (count),
    .match_ev  (match_ev),
    .wrap_ev   (wrap_ev)
  );

  always_comb begin
    ev_set         = '0;
    ev_ack         = '0;
    ev_set[EV_OVF] = wrap_ev;
    ev_set[EV_CMP] = match_ev;
    ev_ack[EV_OVF] = ovf_ack;
    ev_ack[EV_CMP] = cmp_ack;
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
    tick_timer_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set  (ev_set[g]),
      .ack  (ev_ack[g]),
      .flag (ev_flag[g])
    );
  end

  assign ovf_flag = ev_flag[EV_OVF];
  assign cmp_flag = ev_flag[EV_CMP];

  tick_timer_wave u_wave (
    .clk      (clk),
    .rst      (rst),
    .match_ev (match_ev),
    .out_mode (out_mode),
    .wave     (wave_out)
  );
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [2:0]   mode,
  input logic [1:0]   out_mode,
  input logic         cnt_wr,
  input logic         ovf_ack,
  input logic         cmp_ack,
  input logic [W-1:0] count,
  input logic [W-1:0] compare,
  input logic         ovf_flag,
  input logic         cmp_flag,
  input logic         wave_out
);
  localparam logic [W-1:0] TOPV = {W{1'b1}};

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(count)); // R2
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && mode == 3'd0 && count == TOPV) |=> (count == '0 && ovf_flag)); // R4
  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && mode == 3'd2 && count == compare) |=> (count == '0 && cmp_flag)); // R6
  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && mode == 3'd0 && count == TOPV && ovf_ack) |=> ovf_flag); // R5
  AST_OVF_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ovf_ack && !tick) |=> !ovf_flag); // R5
  AST_CMP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !cmp_ack) |=> cmp_flag); // R5
  AST_WAVE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && (mode == 3'd0 || mode == 3'd2) && count == compare && out_mode == 2'd1)
      |=> (wave_out != $past(wave_out))); // R10
  AST_WAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!tick || cnt_wr || out_mode != 2'd1) |=> $stable(wave_out)); // R10
endmodule

bind tick_timer tick_timer_checker #(.W(W)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .mode     (mode),
  .out_mode (out_mode),
  .cnt_wr   (cnt_wr),
  .ovf_ack  (ovf_ack),
  .cmp_ack  (cmp_ack),
  .count    (count),
  .compare  (compare),
  .ovf_flag (ovf_flag),
  .cmp_flag (cmp_flag),
  .wave_out (wave_out)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [1:0] out_mode = 2'd0;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_wdata = 8'd0;
  logic       cmp_wr = 1'b0;
  logic [7:0] cmp_wdata = 8'd0;
  logic       ovf_ack = 1'b0;
  logic       cmp_ack = 1'b0;
  logic [7:0] count;
  logic [7:0] compare;
  logic       ovf_flag;
  logic       cmp_flag;
  logic       wave_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .out_mode(out_mode),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .ovf_ack(ovf_ack), .cmp_ack(cmp_ack), .count(count), .compare(compare),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .wave_out(wave_out)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_tick();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic wr_count(input logic [7:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; step(); cnt_wr = 1'b0;
  endtask

  task automatic wr_cmp(input logic [7:0] v);
    cmp_wr = 1'b1; cmp_wdata = v; step(); cmp_wr = 1'b0;
  endtask

  task automatic ack_all();
    ovf_ack = 1'b1; cmp_ack = 1'b1; step(); ovf_ack = 1'b0; cmp_ack = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step(); rst = 1'b0; #0;
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 compare", compare, 0);
    check("R1 ovf", ovf_flag, 0);
    check("R1 cmp", cmp_flag, 0);
    check("R1 wave", wave_out, 0);

    // R3 R4 free-running sweep across wrap, compare parked at 0x80
    mode = 3'd0; out_mode = 2'd0;
    wr_cmp(8'h80);
    wr_count(8'hF0);
    for (int n = 1; n <= 24; n++) begin
      do_tick();
      check("R3 free count", count, (8'hF0 + n) % 256);
      check("R4 ovf at zero", ovf_flag, (n >= 16) ? 1 : 0);
    end
    // R2 no tick: hold
    for (int n = 0; n < 5; n++) begin
      step();
      check("R2 hold without tick", count, 8);
    end
    // R5 flag sticky, then cleared by ack
    check("R5 ovf sticky", ovf_flag, 1);
    ack_all();
    check("R5 ovf cleared by ack", ovf_flag, 0);

    // R3 full free-running lap, R7 compare flag in mode 0 at 0x80, no clear
    wr_count(8'h00);
    ack_all();
    for (int n = 1; n <= 256; n++) begin
      do_tick();
      check("R3 full lap", count, n % 256);
      check("R7 free-mode match flag", cmp_flag, (n >= 129) ? 1 : 0);
    end
    check("R4 ovf after lap", ovf_flag, 1);

    // R5 set and ack in the same cycle: set wins
    ack_all();
    wr_count(8'hFF);
    tick = 1'b1; ovf_ack = 1'b1; step(); tick = 1'b0; ovf_ack = 1'b0;
    check("R5 set beats ack", ovf_flag, 1);
    check("R4 count zero with flag", count, 0);

    // R2 unsupported mode holds on ticks
    ack_all();
    wr_count(8'h80);
    mode = 3'd3; out_mode = 2'd1;
    for (int n = 0; n < 4; n++) begin
      do_tick();
      check("R2 mode 3 holds", count, 8'h80);
    end
    check("R2 mode 3 no flag", cmp_flag, 0);
    check("R2 mode 3 no toggle", wave_out, 0);

    // R6 R7 R10 compare-clear sweep over compare 0..15
    mode = 3'd2; out_mode = 2'd1;
    for (int c = 0; c < 16; c++) begin
      automatic logic w0;
      wr_cmp(c[7:0]);
      wr_count(8'h00);
      ack_all();
      w0 = wave_out;
      for (int k = 1; k <= 3 * (c + 1); k++) begin
        do_tick();
        check("R6 ctc count", count, k % (c + 1));
        check("R7 ctc flag", cmp_flag, (k >= c + 1) ? 1 : 0);
        check("R10 wave parity", wave_out, w0 ^ ((k / (c + 1)) % 2));
      end
      check("R6 no overflow in short period", ovf_flag, 0);
    end

    // R10 other output mode holds wave across matches
    out_mode = 2'd2;
    begin
      automatic logic w1 = wave_out;
      wr_cmp(8'd3); wr_count(8'd0);
      for (int k = 0; k < 12; k++) do_tick();
      check("R10 hold when not toggle", wave_out, w1);
    end

    // R8 compare lowered below count: miss, wrap, then match
    out_mode = 2'd0;
    wr_cmp(8'h30);
    wr_count(8'h20);
    wr_cmp(8'h10);
    ack_all();
    check("R8 new compare visible", compare, 8'h10);
    for (int n = 1; n <= 241; n++) begin
      do_tick();
      if (n <= 223)      check("R8 climb", count, 8'h20 + n);
      else if (n <= 240) check("R8 after wrap", count, n - 224);
      else               check("R8 cleared at new top", count, 0);
      check("R8 overflow", ovf_flag, (n >= 224) ? 1 : 0);
      check("R8 match late", cmp_flag, (n >= 241) ? 1 : 0);
    end

    // R9 count write in a matching tick: write wins, nothing flagged
    wr_cmp(8'd5);
    wr_count(8'd5);
    ack_all();
    tick = 1'b1; cnt_wr = 1'b1; cnt_wdata = 8'h40; step();
    tick = 1'b0; cnt_wr = 1'b0;
    check("R9 write wins", count, 8'h40);
    check("R9 no match flag", cmp_flag, 0);
    wr_count(8'hFF);
    tick = 1'b1; cnt_wr = 1'b1; cnt_wdata = 8'h07; step();
    tick = 1'b0; cnt_wr = 1'b0;
    check("R9 write at max", count, 8'h07);
    check("R9 no overflow flag", ovf_flag, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule